// File: doc/BRIEF.md
# Word-to-Byte FIFO Data Port

This block sits between the 32-bit register file of a serial host controller and the byte-wide queues that feed and drain its serial engine. A register write to the transmit data port splits the word into four bytes and queues them, lowest byte first. A register read of the receive data port takes up to four bytes from the receive queue and packs them into a word, again lowest byte first. Both queues are held inside the block, and each has its own depth in bytes set by a parameter.

The serial engine removes transmit bytes one at a time and adds receive bytes one at a time, in the same cycles as the register port if it needs to. The block reports full and empty flags and the occupancy of each queue in whole words, with a partial word counted as one. When a word access finds too little room or too little data, the block still moves what it can and raises a one-cycle error pulse. The status bit that reports byte order always reads as little-endian.

Top module: `word_fifo_port`

## Requirements
- R1: After reset, both queues are empty. The empty flags read 1, the full flags read 0, both word depths read 0, the receive word reads 0 and both error pulses read 0.
- R2: A transmit write with at least four free byte slots queues bits [7:0], [15:8], [23:16] and [31:24] in that order. The engine sees them on eng_tx_byte_o one at a time, in that order, with eng_tx_valid_o high whenever the transmit queue holds a byte.
- R3: A transmit write that finds fewer than four free slots queues only as many low-order bytes as fit and discards the rest. tx_overflow_o is then high for exactly the one cycle after the write. Free slots are counted before any engine removal made in the same cycle.
- R4: A receive read removes up to four bytes. The first byte removed lands in bits [7:0] and each later byte in the next higher byte. The word appears on rx_rdata_o in the cycle after the read and holds until the next read.
- R5: A receive read that finds fewer than four bytes returns the bytes it finds with the upper bytes zero. rx_underflow_o is then high for the one cycle after the read, and the receive queue is left empty unless the engine added a byte in that same cycle.
- R6: After any receive read, rx_full_o is low in the following cycle.
- R7: Full means occupancy equals the configured depth and empty means occupancy is zero. The word depth outputs equal the byte occupancy divided by four, rounded up. All of these reflect the state after the last clock edge.
- R8: byte_order_o is always 0, meaning the least significant byte goes first.
- R9: When the register port and the engine both act on the same queue in one cycle, both operations take effect and the occupancy changes by bytes added minus bytes removed. For receive, engine acceptance is judged on the occupancy before that cycle's read.
- R10: An engine removal from an empty transmit queue has no effect. An engine addition to a full receive queue is dropped and does not change the queue contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr_i | input | 1 | Transmit data word write strobe |
| tx_wdata_i | input | 32 | Transmit data word |
| rx_rd_i | input | 1 | Receive data word read strobe |
| rx_rdata_o | output | 32 | Last assembled receive word |
| eng_tx_pop_i | input | 1 | Engine removes one transmit byte |
| eng_tx_byte_o | output | 8 | Head byte of the transmit queue |
| eng_tx_valid_o | output | 1 | Transmit queue holds at least one byte |
| eng_rx_push_i | input | 1 | Engine adds one receive byte |
| eng_rx_byte_i | input | 8 | Receive byte from the engine |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_words_o | output | 8 | Transmit occupancy in words, rounded up |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_words_o | output | 8 | Receive occupancy in words, rounded up |
| byte_order_o | output | 1 | Byte order status, 0 for little-endian |
| tx_overflow_o | output | 1 | One-cycle pulse: a transmit write lost bytes |
| rx_underflow_o | output | 1 | One-cycle pulse: a receive read came up short |

## Verification
Two pairs of operations can land in one cycle. A register-side word write can coincide with an engine byte removal on the transmit queue, and a register-side word read can coincide with an engine byte addition on the receive queue. Directed cases provoke both: one fills the transmit queue to one free slot and then writes and removes together, and one reads a full receive queue while a byte arrives. Random phases then drive all four strobes independently with biased rates, so that both queues spend long stretches near full and near empty. Each cycle is judged against byte queues kept in the bench, which apply the rule that space and data are counted before the cycle's own transfers.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = BYTE_W * WORD_BYTES;
  localparam int unsigned LVL_W      = 8;
endpackage

// File: rtl/byte_queue.sv
module byte_queue
  import wbp_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned WR_LANES = 1,
  parameter int unsigned RD_LANES = 1,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic [WR_LANES*BYTE_W-1:0]   push_data_i,
  input  logic                         pop_i,
  output logic [RD_LANES*BYTE_W-1:0]   head_o,
  output logic [CW-1:0]                count_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] WL_C    = CW'(WR_LANES);
  localparam logic [CW-1:0] RL_C    = CW'(RD_LANES);

  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]     cnt_q, cnt_d, free_w, n_wr, n_rd;
  logic              upd_en;

  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] base,
                                             input logic [CW-1:0] off);
    logic [PW+1:0] s;
    s = {2'b00, base} + (PW+2)'(off);
    if (s >= (PW+2)'(DEPTH)) s = s - (PW+2)'(DEPTH);
    return s[PW-1:0];
  endfunction

  // Space and data are judged on the occupancy before this cycle.
  always_comb begin
    free_w = DEPTH_C - cnt_q;
    n_wr   = push_i ? ((free_w < WL_C) ? free_w : WL_C) : '0;
    n_rd   = pop_i  ? ((cnt_q  < RL_C) ? cnt_q  : RL_C) : '0;
    wptr_d = wrap_add(wptr_q, n_wr);
    rptr_d = wrap_add(rptr_q, n_rd);
    cnt_d  = cnt_q + n_wr - n_rd;
    upd_en = (n_wr != '0) || (n_rd != '0);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < int'(WR_LANES); k++) begin
      if (CW'(k) < n_wr) mem_q[wrap_add(wptr_q, CW'(k))] <= push_data_i[k*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < RD_LANES; g++) begin : g_head
    assign head_o[g*BYTE_W +: BYTE_W] = mem_q[wrap_add(rptr_q, CW'(g))];
  end

  assign count_o = cnt_q;

  // R9: occupancy never exceeds the configured depth
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C);

  // R10: removal from an empty queue with nothing arriving leaves it empty
  a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/level_report.sv
module level_report
  import wbp_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0]    cnt_i,
  output logic             full_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] words_o
);
  logic [CW+1:0] sum;

  assign sum     = {2'b00, cnt_i} + (CW+2)'(WORD_BYTES - 1);
  assign words_o = LVL_W'(sum >> 2);
  assign full_o  = (cnt_i == CW'(DEPTH));
  assign empty_o = (cnt_i == '0);
endmodule

// File: rtl/word_fifo_port.sv
module word_fifo_port
  import wbp_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr_i,
  input  logic [WORD_W-1:0] tx_wdata_i,
  input  logic              rx_rd_i,
  output logic [WORD_W-1:0] rx_rdata_o,
  input  logic              eng_tx_pop_i,
  output logic [BYTE_W-1:0] eng_tx_byte_o,
  output logic              eng_tx_valid_o,
  input  logic              eng_rx_push_i,
  input  logic [BYTE_W-1:0] eng_rx_byte_i,
  output logic              tx_full_o,
  output logic              tx_empty_o,
  output logic [LVL_W-1:0]  tx_words_o,
  output logic              rx_full_o,
  output logic              rx_empty_o,
  output logic [LVL_W-1:0]  rx_words_o,
  output logic              byte_order_o,
  output logic              tx_overflow_o,
  output logic              rx_underflow_o
);
  localparam int unsigned TX_CW = $clog2(TX_DEPTH + 1);
  localparam int unsigned RX_CW = $clog2(RX_DEPTH + 1);

  logic [TX_CW-1:0]  tx_cnt, tx_free;
  logic [RX_CW-1:0]  rx_cnt;
  logic [WORD_W-1:0] rx_head, rx_word_d, rx_rdata_q;
  logic              ovf_d, ovf_q, udf_d, udf_q;

  byte_queue #(.DEPTH(TX_DEPTH), .WR_LANES(WORD_BYTES), .RD_LANES(1)) u_txq (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (tx_wr_i),
    .push_data_i (tx_wdata_i),
    .pop_i       (eng_tx_pop_i),
    .head_o      (eng_tx_byte_o),
    .count_o     (tx_cnt)
  );

  byte_queue #(.DEPTH(RX_DEPTH), .WR_LANES(1), .RD_LANES(WORD_BYTES)) u_rxq (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (eng_rx_push_i),
    .push_data_i (eng_rx_byte_i),
    .pop_i       (rx_rd_i),
    .head_o      (rx_head),
    .count_o     (rx_cnt)
  );

  level_report #(.DEPTH(TX_DEPTH)) u_txlvl (
    .cnt_i   (tx_cnt),
    .full_o  (tx_full_o),
    .empty_o (tx_empty_o),
    .words_o (tx_words_o)
  );

  level_report #(.DEPTH(RX_DEPTH)) u_rxlvl (
    .cnt_i   (rx_cnt),
    .full_o  (rx_full_o),
    .empty_o (rx_empty_o),
    .words_o (rx_words_o)
  );

  // Lanes beyond the available data read as zero.
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_rxlane
    assign rx_word_d[g*BYTE_W +: BYTE_W] =
      (RX_CW'(g) < rx_cnt) ? rx_head[g*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    tx_free = TX_CW'(TX_DEPTH) - tx_cnt;
    ovf_d   = tx_wr_i && (tx_free < TX_CW'(WORD_BYTES));
    udf_d   = rx_rd_i && (rx_cnt < RX_CW'(WORD_BYTES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rdata_q <= '0;
      ovf_q      <= 1'b0;
      udf_q      <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      udf_q <= udf_d;
      if (rx_rd_i) rx_rdata_q <= rx_word_d;
    end
  end

  assign rx_rdata_o     = rx_rdata_q;
  assign tx_overflow_o  = ovf_q;
  assign rx_underflow_o = udf_q;
  assign eng_tx_valid_o = !tx_empty_o;
  assign byte_order_o   = 1'b0;

  // R3: an overflow pulse follows a transmit write
  a_r3_ovf_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow_o |-> $past(tx_wr_i));
  // R3: a lossy write leaves the queue full unless the engine took a byte
  a_r3_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow_o |-> (tx_full_o || $past(eng_tx_pop_i)));
  // R5: an underflow pulse follows a receive read
  a_r5_udf_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underflow_o |-> $past(rx_rd_i));
  // R5: a short read drains the queue unless the engine added a byte
  a_r5_udf_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underflow_o |-> (rx_empty_o || $past(eng_rx_push_i)));
  // R6: a read always clears the full flag
  a_r6_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_i |=> !rx_full_o);
  // R4: the returned word holds between reads
  a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rd_i |=> $stable(rx_rdata_o));
endmodule

// File: tb/word_fifo_port_bench.sv
`timescale 1ns/1ps
module word_fifo_port_bench;
  localparam int TXD = 16;
  localparam int RXD = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_wr_i, rx_rd_i, eng_tx_pop_i, eng_rx_push_i;
  logic [31:0] tx_wdata_i, rx_rdata_o;
  logic [7:0]  eng_tx_byte_o, eng_rx_byte_i;
  logic        eng_tx_valid_o, tx_full_o, tx_empty_o, rx_full_o, rx_empty_o;
  logic [7:0]  tx_words_o, rx_words_o;
  logic        byte_order_o, tx_overflow_o, rx_underflow_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [7:0]  tx_q[$];
  logic [7:0]  rx_q[$];
  logic [31:0] exp_rdata;
  bit          exp_ovf, exp_udf;

  always #4 clk = ~clk;

  word_fifo_port #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_word_fifo_port (
    .clk(clk), .rst_n(rst_n),
    .tx_wr_i(tx_wr_i), .tx_wdata_i(tx_wdata_i),
    .rx_rd_i(rx_rd_i), .rx_rdata_o(rx_rdata_o),
    .eng_tx_pop_i(eng_tx_pop_i), .eng_tx_byte_o(eng_tx_byte_o), .eng_tx_valid_o(eng_tx_valid_o),
    .eng_rx_push_i(eng_rx_push_i), .eng_rx_byte_i(eng_rx_byte_i),
    .tx_full_o(tx_full_o), .tx_empty_o(tx_empty_o), .tx_words_o(tx_words_o),
    .rx_full_o(rx_full_o), .rx_empty_o(rx_empty_o), .rx_words_o(rx_words_o),
    .byte_order_o(byte_order_o), .tx_overflow_o(tx_overflow_o), .rx_underflow_o(rx_underflow_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] words_of(input int n);
    return 32'((n + 3) / 4);
  endfunction

  task automatic check_all(input string tag);
    chk(tag, tx_full_o,  tx_q.size() == TXD);
    chk(tag, tx_empty_o, tx_q.size() == 0);
    chk(tag, tx_words_o, words_of(tx_q.size()));
    chk(tag, rx_full_o,  rx_q.size() == RXD);
    chk(tag, rx_empty_o, rx_q.size() == 0);
    chk(tag, rx_words_o, words_of(rx_q.size()));
    chk("R3", tx_overflow_o, exp_ovf);
    chk("R5", rx_underflow_o, exp_udf);
    chk("R4", rx_rdata_o, exp_rdata);
    chk("R8", byte_order_o, 1'b0);
  endtask

  task automatic step(input bit wr, input logic [31:0] wd, input bit tp,
                      input bit rd, input bit rp, input logic [7:0] rb, input string tag);
    int free, nw, k, rx_pre;
    logic [31:0] w;
    bit tpop_ok;
    chk("R2", eng_tx_valid_o, tx_q.size() > 0);
    if (tx_q.size() > 0) chk("R2", eng_tx_byte_o, tx_q[0]);
    tx_wr_i = wr; tx_wdata_i = wd; eng_tx_pop_i = tp;
    rx_rd_i = rd; eng_rx_push_i = rp; eng_rx_byte_i = rb;
    exp_ovf = 1'b0;
    tpop_ok = tp && (tx_q.size() > 0);
    if (wr) begin
      free = TXD - tx_q.size();
      nw = (free < 4) ? free : 4;
      exp_ovf = (nw < 4);
      for (int j = 0; j < nw; j++) tx_q.push_back(wd[j*8 +: 8]);
    end
    if (tpop_ok) void'(tx_q.pop_front());
    rx_pre = rx_q.size();
    exp_udf = 1'b0;
    if (rd) begin
      k = (rx_pre < 4) ? rx_pre : 4;
      w = '0;
      for (int j = 0; j < k; j++) w[j*8 +: 8] = rx_q.pop_front();
      exp_rdata = w;
      exp_udf = (k < 4);
    end
    if (rp && rx_pre < RXD) rx_q.push_back(rb);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    tx_wr_i = 0; tx_wdata_i = '0; rx_rd_i = 0;
    eng_tx_pop_i = 0; eng_rx_push_i = 0; eng_rx_byte_i = '0;
    exp_rdata = '0; exp_ovf = 0; exp_udf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    chk("R1", eng_tx_valid_o, 1'b0);

    // R2: byte order on the engine side
    step(1, 32'h44332211, 0, 0, 0, 8'h00, "R2");
    for (int i = 0; i < 4; i++) step(0, '0, 1, 0, 0, 8'h00, "R2");
    // R3: fill, then a write with no room
    for (int i = 0; i < 4; i++) step(1, 32'hA0B0C0D0 + i, 0, 0, 0, 8'h00, "R7");
    step(1, 32'hDEADBEEF, 0, 0, 0, 8'h00, "R3");
    // R9: one free slot, write and engine removal together
    step(0, '0, 1, 0, 0, 8'h00, "R7");
    step(1, 32'h5566_7788, 1, 0, 0, 8'h00, "R9");
    for (int i = 0; i < 15; i++) step(0, '0, 1, 0, 0, 8'h00, "R7");
    // R10: removal from an empty transmit queue
    step(0, '0, 1, 0, 0, 8'h00, "R10");

    // R5: read of an empty receive queue
    step(0, '0, 0, 1, 0, 8'h00, "R5");
    for (int i = 0; i < 5; i++) step(0, '0, 0, 0, 1, 8'h10 + 8'(i), "R7");
    step(0, '0, 0, 1, 0, 8'h00, "R4");
    step(0, '0, 0, 1, 0, 8'h00, "R5");
    // R10: overfill the receive queue, then R6 read during a push
    for (int i = 0; i < RXD + 1; i++) step(0, '0, 0, 0, 1, 8'h40 + 8'(i), "R10");
    step(0, '0, 0, 1, 1, 8'hEE, "R6");
    for (int i = 0; i < 4; i++) step(0, '0, 0, 1, 0, 8'h00, "R4");

    // Random phases: alternate fill-heavy and drain-heavy
    for (int i = 0; i < 4000; i++) begin
      int ph;
      ph = (i / 200) % 2;
      step(($urandom % 100) < (ph ? 15 : 45), $urandom,
           ($urandom % 100) < (ph ? 80 : 30),
           ($urandom % 100) < (ph ? 10 : 40),
           ($urandom % 100) < (ph ? 70 : 25),
           8'($urandom), "R9");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule